// File: doc/BRIEF.md
# Modulo-Six Counter Built on a Saturating Up Counter

This block produces a count that cycles through the values 0 to 5. Its storage is a single 5-bit up counter with an enable and a synchronous clear. That counter saturates: once it reaches 31 it stays there rather than wrapping. The wrap to zero does not come from the counter. A small decode stage drives the counter's clear when the count is at 5 and counting is enabled, so the value after 5 is 0. No second register is involved.

Callers use it as a free-running or gated divide-by-six sequencer. The terminal flag is high for the whole cycle in which the count sits at 5. A parameter can disconnect the wrap decode. This leaves the bare saturating counter, and in that configuration the output widens to the full 5 bits. That variant is used to check the saturation behaviour on its own.

Top module: `sat_mod_counter`

## Requirements
- R1: When `srst_i` is high at a rising clock edge, `count_o` is 0 after that edge, whatever `cnt_en_i` is. Reset takes priority over enable.
- R2: When `srst_i` and `cnt_en_i` are both low at an edge, `count_o` keeps its value across that edge.
- R3: When `cnt_en_i` is high, `srst_i` is low and the count is below its terminal value, `count_o` rises by exactly one at the edge.
- R4: In the default configuration (`WRAP_EN`=1, `MODULUS`=6), an edge with the count at 5, enable high and reset low returns `count_o` to 0. The visited sequence is therefore 0,1,2,3,4,5,0.
- R5: With the count at 5 and `cnt_en_i` low, the count stays at 5 and does not wrap.
- R6: `term_o` is high exactly when `count_o` equals the terminal value: 5 in the default configuration, 31 when `WRAP_EN`=0.
- R7: With `WRAP_EN`=0, `count_o` is the full 5-bit count. It climbs to 31, then holds at 31 while enable stays high, until a reset clears it.
- R8: In the default configuration the internal count never exceeds 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| srst_i | input | 1 | Synchronous reset, active high |
| cnt_en_i | input | 1 | Count enable, active high |
| count_o | output | OUT_W (3 by default, 5 when WRAP_EN=0) | Current count value |
| term_o | output | 1 | High while the count is at its terminal value |

## Verification
The hardest situation to reach is saturation. With the wrap decode connected, the counter can never get past 5, so the hold-at-31 path cannot be reached through the default top at all. The bench therefore runs a second instance with `WRAP_EN`=0. It keeps the enable high for long stretches on that instance, so the count climbs to 31 and then sits at the ceiling for many further enabled edges before a reset arrives together with enable. The wrapping instance gets an enable pattern that stalls the count at 5 for several cycles before releasing it.

// File: rtl/sat_mod_pkg.sv
package sat_mod_pkg;
  function automatic int unsigned out_width(input int unsigned inner_w,
                                            input int unsigned modulus,
                                            input bit          wrap_en);
    return wrap_en ? $clog2(modulus) : inner_w;
  endfunction
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int unsigned W = 5
) (
  input  logic         clk_i,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         armed_q;

  assign at_max_o = (cnt_q == MAX_VAL);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (clr_i)                 cnt_q <= '0;
    else if (en_i && !at_max_o) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (clr_i) armed_q <= 1'b1;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!armed_q)
    clr_i |=> (cnt_q == '0)); // R1
  AST_CEILING_HOLD: assert property (@(posedge clk_i) disable iff (!armed_q)
    (at_max_o && !clr_i) |=> (cnt_q == MAX_VAL)); // R7
endmodule

// File: rtl/wrap_decode.sv
module wrap_decode #(
  parameter int unsigned W       = 5,
  parameter int unsigned MODULUS = 6,
  parameter bit          WRAP_EN = 1'b1
) (
  input  logic         ext_rst_i,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  output logic         clr_o,
  output logic         term_o
);
  localparam logic [W-1:0] TERM_VAL = WRAP_EN ? W'(MODULUS - 1) : {W{1'b1}};

  logic at_term;
  assign at_term = (cnt_i == TERM_VAL);
  assign term_o  = at_term;

  generate
    if (WRAP_EN) begin : g_wrap
      assign clr_o = ext_rst_i | (at_term & en_i);
    end else begin : g_bare
      assign clr_o = ext_rst_i;
    end
  endgenerate
endmodule

// File: rtl/sat_mod_counter.sv
module sat_mod_counter
  import sat_mod_pkg::*;
#(
  parameter int unsigned INNER_W = 5,
  parameter int unsigned MODULUS = 6,
  parameter bit          WRAP_EN = 1'b1,
  localparam int unsigned OUT_W  = out_width(INNER_W, MODULUS, WRAP_EN)
) (
  input  logic             clk_i,
  input  logic             srst_i,
  input  logic             cnt_en_i,
  output logic [OUT_W-1:0] count_o,
  output logic             term_o
);
  localparam logic [INNER_W-1:0] TERM_VAL =
    WRAP_EN ? INNER_W'(MODULUS - 1) : {INNER_W{1'b1}};

  logic [INNER_W-1:0] cnt;
  logic               clr;
  logic               at_max;
  logic               armed_q;

  wrap_decode #(.W(INNER_W), .MODULUS(MODULUS), .WRAP_EN(WRAP_EN)) u_decode (
    .ext_rst_i (srst_i),
    .en_i      (cnt_en_i),
    .cnt_i     (cnt),
    .clr_o     (clr),
    .term_o    (term_o)
  );

  sat_counter #(.W(INNER_W)) u_core (
    .clk_i    (clk_i),
    .clr_i    (clr),
    .en_i     (cnt_en_i),
    .cnt_o    (cnt),
    .at_max_o (at_max)
  );

  assign count_o = cnt[OUT_W-1:0];

  always_ff @(posedge clk_i) begin
    if (srst_i) armed_q <= 1'b1;
  end

  AST_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!armed_q)
    (srst_i && cnt_en_i) |=> (cnt == '0)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!armed_q)
    (!srst_i && !cnt_en_i) |=> $stable(cnt)); // R2
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!armed_q)
    (!srst_i && cnt_en_i && cnt != TERM_VAL) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!armed_q)
    (WRAP_EN && !srst_i && cnt_en_i && cnt == TERM_VAL) |=> (cnt == '0)); // R4
  AST_NO_SATURATE: assert property (@(posedge clk_i) disable iff (!armed_q)
    WRAP_EN |-> (!at_max && cnt <= TERM_VAL)); // R8
endmodule

// File: tb/sat_mod_counter_tb.sv
module sat_mod_counter_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_a, en_a, rst_b, en_b;
  logic [2:0] cnt_a;
  logic [4:0] cnt_b;
  logic       term_a, term_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_a  = 0;
  int exp_b  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_mod_counter u_dut (
    .clk_i(clk), .srst_i(rst_a), .cnt_en_i(en_a), .count_o(cnt_a), .term_o(term_a));

  sat_mod_counter #(.WRAP_EN(1'b0)) u_dut_sat (
    .clk_i(clk), .srst_i(rst_b), .cnt_en_i(en_b), .count_o(cnt_b), .term_o(term_b));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic ra, input logic ea, input logic rb, input logic eb);
    string tag_a;
    rst_a = ra; en_a = ea; rst_b = rb; eb = eb; en_b = eb;
    @(posedge clk);
    #1;
    if (ra)                         tag_a = "R1 reset";
    else if (!ea && exp_a == 5)     tag_a = "R5 hold at 5";
    else if (!ea)                   tag_a = "R2 hold";
    else if (exp_a == 5)            tag_a = "R4 wrap";
    else                            tag_a = "R3 increment";
    exp_a = ra ? 0 : (ea ? (exp_a + 1) % 6 : exp_a);
    exp_b = rb ? 0 : ((eb && exp_b < 31) ? exp_b + 1 : exp_b);
    check(tag_a, int'(cnt_a), exp_a);
    check("R6 terminal flag", int'(term_a), int'(exp_a == 5));
    check("R8 bound", int'(cnt_a <= 3'd5), 1);
    check(rb ? "R1 reset (sat)" : "R7 saturating count", int'(cnt_b), exp_b);
    check("R6/R7 ceiling flag", int'(term_b), int'(exp_b == 31));
  endtask

  initial begin
    rst_a = 1'b1; en_a = 1'b0; rst_b = 1'b1; en_b = 1'b0;
    @(negedge clk);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b0);
    // enabled run over many full periods; bare counter reaches and sits at 31
    for (int i = 0; i < 60; i++) step(1'b0, 1'b1, 1'b0, 1'b1);
    // bring wrapping count to 5, then stall there (R5)
    while (exp_a != 5) step(1'b0, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1);  // wrap after stall (R4)
    // patterned enable sweep
    for (int i = 0; i < 300; i++)
      step(1'b0, ((i * 5 + i / 3) % 7) != 2, 1'b0, (i % 11) != 4);
    // reset with enable high at count 5 and at the ceiling (R1 priority)
    while (exp_a != 5) step(1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    // every start value with every reset/enable combination
    for (int s = 0; s < 6; s++)
      for (int c = 0; c < 4; c++) begin
        step(1'b1, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < s; k++) step(1'b0, 1'b1, 1'b0, 1'b1);
        step(c[1], c[0], c[1], c[0]);
      end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule